// File: doc/BRIEF.md
# Strobe Window Sequencer

This block produces the acquisition window of a pixel front end. While its strobe output is high, hits that arrive are latched into an event buffer downstream; hits outside the window are lost. A one-cycle acknowledge pulse marks every trigger that actually opens a window, so the event bookkeeping logic can reserve one entry per accepted trigger.

Two operating modes exist. In one-shot mode each external trigger opens a single window of programmable length. In continuous mode the windows repeat with a short programmable gap between them. The start of each window then comes either from an internal period timer, which re-opens the window as soon as the gap has elapsed, or from an external trigger accepted once the previous window and its gap have ended. Triggers that arrive while the sequencer is busy are not honoured. They are counted instead.

Top module: `strobe_seq`

## Requirements
- R1: After reset, strobe, trig_ack and drop_count are all zero and the sequencer is idle.
- R2: In one-shot mode (cont_mode=0), an ext_trig sampled high while idle and enabled raises strobe on the next cycle for exactly strobe_len cycles. Strobe then stays low until another trigger arrives.
- R3: trig_ack is high for exactly one cycle per window, in the first cycle that strobe is high.
- R4: A strobe_len or gap_len of zero behaves as a value of one.
- R5: In continuous mode with the internal source (cont_mode=1, int_src=1) and enable high, windows start without any trigger and alternate strobe_len cycles high with gap_len cycles low.
- R6: In continuous mode with the external source (cont_mode=1, int_src=0), each accepted trigger gives strobe_len high cycles followed by gap_len low cycles before the next trigger can be accepted.
- R7: An enabled ext_trig sampled while a window or gap is in progress in an external-source mode opens nothing and raises drop_count by one, saturating at its all-ones value. With the internal source, ext_trig is ignored and is not counted.
- R8: cont_mode and int_src are taken over only while idle. A mode change during a window takes effect after that window has ended.
- R9: With enable low, no window starts and triggers are not counted. A window already open runs to its full length, and the internal source stops at the end of its gap.
- R10: strobe_len is captured when a window opens. Changing it during the window does not alter that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new windows to start |
| cont_mode | input | 1 | 0 = one-shot, 1 = continuous |
| int_src | input | 1 | In continuous mode, 1 = internal period timer, 0 = external trigger |
| ext_trig | input | 1 | External trigger, sampled every cycle |
| strobe_len | input | CNT_W | Window length in cycles (0 acts as 1) |
| gap_len | input | CNT_W | Gap between continuous windows in cycles (0 acts as 1) |
| strobe | output | 1 | Registered acquisition window |
| trig_ack | output | 1 | One-cycle pulse per opened window |
| drop_count | output | DROP_W | Saturating count of refused triggers |

## Verification
A trigger sampled at a clock edge shows up as strobe and trig_ack one cycle later. drop_count likewise moves one cycle after a refused trigger. In continuous internal mode the next window rises on the cycle right after the last gap cycle, and a mode change made during a one-shot window costs exactly one idle low cycle. The bench drives on the falling edge and samples on the next falling edge, so every check reads the registered value produced by the rising edge in between. It measures run lengths of high and low strobe cycles by counting those samples.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/span_reload.sv
// Turns a programmed span (cycles) into a down-counter reload value;
// a zero span is handled as a span of one.
module span_reload #(
  parameter int W = 16
) (
  input  logic [W-1:0] span,
  output logic [W-1:0] reload
);
  always_comb begin
    if (span == '0) reload = '0;
    else            reload = span - W'(1);
  end
endmodule

// File: rtl/window_timer.sv
// Down counter; expired is high when the count has reached zero.
module window_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/drop_tally.sv
// Saturating event counter for refused triggers.
module drop_tally #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (bump && (count != '1))   count <= count + W'(1);
  end
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cont_mode,
  input  logic              int_src,
  input  logic              ext_trig,
  input  logic [CNT_W-1:0]  strobe_len,
  input  logic [CNT_W-1:0]  gap_len,
  output logic              strobe,
  output logic              trig_ack,
  output logic [DROP_W-1:0] drop_count
);

  seq_state_t       state_q, state_d;
  logic             act_cont_q, act_int_q;
  logic [CNT_W-1:0] len_rl, gap_rl, t_val;
  logic             t_load, t_exp;
  logic             idle, req_int, act_internal;
  logic             start_idle, wrap, close_open, open_go, drop_bump;

  span_reload #(.W(CNT_W)) u_len_rl (.span(strobe_len), .reload(len_rl));
  span_reload #(.W(CNT_W)) u_gap_rl (.span(gap_len),    .reload(gap_rl));

  window_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  drop_tally #(.W(DROP_W)) u_drops (
    .clk   (clk),
    .rst   (rst),
    .bump  (drop_bump),
    .count (drop_count)
  );

  always_comb begin
    idle         = (state_q == ST_IDLE);
    req_int      = cont_mode && int_src;
    act_internal = act_cont_q && act_int_q;
    // new window from idle: internal source needs no trigger
    start_idle   = idle && enable && (req_int || ext_trig);
    // internal source re-opens straight after the gap if nothing changed
    wrap         = (state_q == ST_GAP) && t_exp && act_internal &&
                   enable && req_int;
    close_open   = (state_q == ST_OPEN) && t_exp;
    open_go      = start_idle || wrap;
    t_load       = open_go || (close_open && act_cont_q);
    t_val        = open_go ? len_rl : gap_rl;
    drop_bump    = enable && ext_trig && !idle && !act_internal;

    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_idle) state_d = ST_OPEN;
      ST_OPEN: if (close_open) state_d = act_cont_q ? ST_GAP : ST_IDLE;
      ST_GAP:  if (t_exp)      state_d = wrap ? ST_OPEN : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      act_cont_q <= 1'b0;
      act_int_q  <= 1'b0;
      strobe     <= 1'b0;
      trig_ack   <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe   <= (state_d == ST_OPEN);
      trig_ack <= open_go;
      if (idle) begin
        act_cont_q <= cont_mode;
        act_int_q  <= int_src;
      end
    end
  end

endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk #(
  parameter int CNT_W  = 16,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [CNT_W-1:0]  strobe_len,
  input logic              strobe,
  input logic              trig_ack,
  input logic [DROP_W-1:0] drop_count
);
  logic              prev_strobe_q;
  logic [CNT_W-1:0]  prev_len_q, exp_q, run_q;
  logic [DROP_W-1:0] prev_drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_strobe_q <= 1'b0;
      prev_len_q    <= '0;
      exp_q         <= '0;
      run_q         <= '0;
      prev_drop_q   <= '0;
    end else begin
      prev_strobe_q <= strobe;
      prev_len_q    <= strobe_len;
      prev_drop_q   <= drop_count;
      if (strobe && !prev_strobe_q) begin
        run_q <= CNT_W'(1);
        exp_q <= (prev_len_q == '0) ? CNT_W'(1) : prev_len_q;
      end else if (strobe) begin
        run_q <= run_q + CNT_W'(1);
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!strobe && !trig_ack && drop_count == '0));

  a_r3_ack_on_rise: assert property (@(posedge clk) disable iff (rst)
    trig_ack |-> (strobe && !prev_strobe_q));

  a_r3_rise_has_ack: assert property (@(posedge clk) disable iff (rst)
    (strobe && !prev_strobe_q) |-> trig_ack);

  a_r9_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> $past(enable));

  // R2 / R4 / R10: the window lasts the length captured when it opened
  a_r2_window_length: assert property (@(posedge clk) disable iff (rst)
    (!strobe && prev_strobe_q) |-> (run_q == exp_q));

  a_r7_drop_step: assert property (@(posedge clk) disable iff (rst)
    (drop_count == prev_drop_q) || (drop_count == prev_drop_q + DROP_W'(1)));
endmodule

bind strobe_seq strobe_seq_chk #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .strobe_len (strobe_len),
  .strobe     (strobe),
  .trig_ack   (trig_ack),
  .drop_count (drop_count)
);

// File: tb/strobe_seq_test.sv
module strobe_seq_test;
  localparam int CW = 16;
  localparam int DW = 3;
  localparam int NOREP = 100;

  typedef struct packed {
    logic          cont;
    logic          isrc;
    logic [CW-1:0] len;
    logic [CW-1:0] gap;
    logic [7:0]    hi;
    logic [7:0]    lo;
  } vec_t;

  // lo = NOREP means no further window may start on its own
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 16'd5,  16'd3, 8'd5,  8'd100}, // R2
    '{1'b0, 1'b0, 16'd1,  16'd0, 8'd1,  8'd100}, // R2
    '{1'b0, 1'b0, 16'd0,  16'd0, 8'd1,  8'd100}, // R4 zero length
    '{1'b1, 1'b1, 16'd4,  16'd2, 8'd4,  8'd2},   // R5
    '{1'b1, 1'b1, 16'd3,  16'd0, 8'd3,  8'd1},   // R4 zero gap
    '{1'b1, 1'b0, 16'd6,  16'd4, 8'd6,  8'd100}, // R6
    '{1'b1, 1'b1, 16'd0,  16'd5, 8'd1,  8'd5},   // R4 / R5
    '{1'b0, 1'b0, 16'd20, 16'd9, 8'd20, 8'd100}  // R2
  };

  logic clk = 1'b0;
  logic rst, enable, cont_mode, int_src, ext_trig;
  logic [CW-1:0] strobe_len, gap_len;
  logic strobe, trig_ack;
  logic [DW-1:0] drop_count;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_drop = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobe_seq #(.CNT_W(CW), .DROP_W(DW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .cont_mode(cont_mode),
    .int_src(int_src), .ext_trig(ext_trig), .strobe_len(strobe_len),
    .gap_len(gap_len), .strobe(strobe), .trig_ack(trig_ack),
    .drop_count(drop_count)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    ext_trig = 1'b1;
    tick();
    ext_trig = 1'b0;
  endtask

  task automatic bump_drop(input int n);
    exp_drop = exp_drop + n;
    if (exp_drop > 7) exp_drop = 7;
  endtask

  // called with strobe already sampled high
  task automatic measure(output int hi, output int lo, output int acks);
    hi = 0; lo = 0; acks = 0;
    while (strobe && hi < 200) begin
      hi++;
      if (trig_ack) acks++;
      tick();
    end
    while (!strobe && lo < NOREP) begin
      lo++;
      tick();
    end
  endtask

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, lo, acks;
    rst = 1'b1; enable = 1'b0; cont_mode = 1'b0; int_src = 1'b0;
    ext_trig = 1'b0; strobe_len = 16'd4; gap_len = 16'd2;
    settle(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    check(strobe == 1'b0, "R1 strobe", int'(strobe), 0);
    check(trig_ack == 1'b0, "R1 ack", int'(trig_ack), 0);
    check(drop_count == '0, "R1 drops", int'(drop_count), 0);

    // table-driven windows: R2 R4 R5 R6, ack per window R3
    for (int i = 0; i < 8; i++) begin
      cont_mode = VECS[i].cont; int_src = VECS[i].isrc;
      strobe_len = VECS[i].len; gap_len = VECS[i].gap;
      enable = 1'b1;
      if (VECS[i].cont && VECS[i].isrc) tick();
      else pulse();
      check(strobe == 1'b1 && trig_ack == 1'b1, "R3 first cycle", int'({strobe, trig_ack}), 3);
      measure(hi, lo, acks);
      check(hi == int'(VECS[i].hi), "R2/R4 high run", hi, int'(VECS[i].hi));
      check(lo == int'(VECS[i].lo), "R5/R6 low run", lo, int'(VECS[i].lo));
      check(acks == 1, "R3 ack count", acks, 1);
      enable = 1'b0;
      settle(50);
    end

    // R7: triggers during an open window are dropped and counted
    cont_mode = 1'b0; int_src = 1'b0; strobe_len = 16'd10; enable = 1'b1;
    pulse();
    for (int k = 0; k < 3; k++) begin
      pulse();
      tick();
    end
    bump_drop(3);
    check(int'(drop_count) == exp_drop, "R7 open drops", int'(drop_count), exp_drop);
    settle(15);
    check(strobe == 1'b0, "R7 no extra window", int'(strobe), 0);

    // R6: trigger inside the gap of external continuous mode is dropped
    cont_mode = 1'b1; int_src = 1'b0; strobe_len = 16'd2; gap_len = 16'd6;
    pulse();
    tick();
    tick();
    pulse();
    bump_drop(1);
    check(strobe == 1'b0, "R6 gap stays low", int'(strobe), 0);
    check(int'(drop_count) == exp_drop, "R6 gap drop", int'(drop_count), exp_drop);
    settle(10);
    check(strobe == 1'b0, "R6 no self restart", int'(strobe), 0);
    pulse();
    check(strobe == 1'b1, "R6 accepted after gap", int'(strobe), 1);
    enable = 1'b0;
    settle(12);

    // R7: internal source ignores external triggers
    cont_mode = 1'b1; int_src = 1'b1; strobe_len = 16'd3; gap_len = 16'd2;
    enable = 1'b1;
    for (int k = 0; k < 5; k++) begin
      pulse();
      tick();
    end
    check(int'(drop_count) == exp_drop, "R7 internal ignore", int'(drop_count), exp_drop);
    enable = 1'b0;
    settle(12);

    // R9: disabled sequencer neither starts nor counts
    cont_mode = 1'b0; int_src = 1'b0; strobe_len = 16'd5;
    pulse();
    settle(4);
    check(strobe == 1'b0, "R9 no start", int'(strobe), 0);
    check(int'(drop_count) == exp_drop, "R9 no count", int'(drop_count), exp_drop);
    // R9: window opened before disabling runs to full length
    enable = 1'b1;
    pulse();
    enable = 1'b0;
    measure(hi, lo, acks);
    check(hi == 5, "R9 window completes", hi, 5);
    check(lo == NOREP, "R9 stays closed", lo, NOREP);

    // R8: mode change mid-window applies only after the window
    cont_mode = 1'b0; int_src = 1'b0; strobe_len = 16'd6; gap_len = 16'd3;
    enable = 1'b1;
    pulse();
    cont_mode = 1'b1; int_src = 1'b1;
    measure(hi, lo, acks);
    check(hi == 6, "R8 window length", hi, 6);
    check(lo == 1, "R8 idle between", lo, 1);
    enable = 1'b0;
    settle(20);

    // R10: length change during a window has no effect on it
    cont_mode = 1'b0; int_src = 1'b0; strobe_len = 16'd4; enable = 1'b1;
    pulse();
    strobe_len = 16'd12;
    measure(hi, lo, acks);
    check(hi == 4, "R10 captured length", hi, 4);

    // R7: saturation of the drop counter
    strobe_len = 16'd20;
    pulse();
    for (int k = 0; k < 6; k++) begin
      pulse();
      tick();
    end
    bump_drop(6);
    check(int'(drop_count) == 7, "R7 saturation", int'(drop_count), 7);
    enable = 1'b0;
    settle(20);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule